// File: doc/BRIEF.md
# Return Stack and Shadow Restore Unit

This block is the return path of a small 8-bit microcontroller core. It keeps a hardware stack of return addresses, fed by subroutine calls and by interrupt entry, and a one-deep shadow copy of the working register (W), the status register and the bank select register. When the core presents an instruction word together with a decode strobe, the block recognises two return instructions. The first returns from an interrupt and may restore the three registers from the shadow copy. The second returns from a subroutine and hands an 8-bit constant to W.

For either instruction the block pops the top return address and presents it as the new program counter, together with the register loads and any interrupt-enable set pulse. These results appear as one-cycle pulses in the clock cycle after the strobe is accepted. That cycle is the instruction's second, idle cycle, and a strobe arriving during it is ignored. Interrupt entry pushes the return address and snapshots W, STATUS and BSR into the shadow copy in the same clock. A plain call pushes only the address. The block drives no program-counter latch registers, so those stay untouched. The ALU, program memory, all other instructions and interrupt priority arbitration live outside this block.

Top module: `ret_stack_unit`

## Requirements
- R1: The word whose bits 15..1 equal 000000000001000 (binary) is the interrupt return. Its bit 0 is the restore flag. When it is accepted, the next cycle shows `pc_load`=1.
- R2: A word with bits 15..8 equal to 0x0C is the literal return. When it is accepted, the next cycle shows `pc_load`=1, `w_load`=1 and `w_val` = instruction bits 7..0, with `status_load`=0 and `bsr_load`=0.
- R3: An accepted return pops the stack. In the following cycle `pc_val` carries the most recently pushed address that has not yet been popped.
- R4: An interrupt return with restore flag 1 loads W, STATUS and BSR from the shadow copy in the cycle after acceptance. With the flag at 0, all three load pulses stay 0.
- R5: `irq_push` captures `w_cur`, `status_cur` and `bsr_cur` into the shadow copy at the same edge as the address push. `call_push` leaves the shadow copy unchanged.
- R6: An interrupt return raises exactly one of two set pulses. It raises `ie_high_set` when `prio_mode`=0, or when `prio_mode`=1 and `hi_in_service`=1. It raises `ie_low_set` when `prio_mode`=1 and `hi_in_service`=0. A literal return raises neither.
- R7: A strobed word that matches neither encoding produces no output pulse and leaves the stack contents unchanged.
- R8: A strobe in the cycle right after an accepted return, which is that instruction's idle second cycle, is ignored.
- R9: When a push request and a decode strobe occur in the same cycle, the push is performed and the strobe is ignored.
- R10: A push onto a stack holding DEPTH entries does not store its address and sets `stk_overflow`, which stays set until reset.
- R11: A pop of an empty stack still produces `pc_load`=1, with `pc_val`=0. It sets `stk_underflow`, which stays set until reset.
- R12: After reset all outputs are 0 and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one edge per instruction cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 16 | Instruction word under decode |
| dec_stb | input | 1 | Instruction word is valid for decode |
| call_push | input | 1 | Subroutine call pushes `ret_addr` |
| irq_push | input | 1 | Interrupt entry pushes `ret_addr` and snapshots registers |
| ret_addr | input | AW | Return address to push |
| w_cur | input | 8 | Current W value |
| status_cur | input | SW | Current STATUS value |
| bsr_cur | input | BW | Current BSR value |
| prio_mode | input | 1 | Two-level interrupt priority enabled |
| hi_in_service | input | 1 | A high-priority interrupt is being serviced |
| pc_load | output | 1 | Load `pc_val` into the program counter |
| pc_val | output | AW | Popped return address |
| w_load | output | 1 | Load `w_val` into W |
| w_val | output | 8 | New W value |
| status_load | output | 1 | Load `status_val` into STATUS |
| status_val | output | SW | New STATUS value |
| bsr_load | output | 1 | Load `bsr_val` into BSR |
| bsr_val | output | BW | New BSR value |
| ie_high_set | output | 1 | Set the high-priority (or single) global interrupt enable |
| ie_low_set | output | 1 | Set the low-priority global interrupt enable |
| stk_overflow | output | 1 | Sticky: a push found the stack full |
| stk_underflow | output | 1 | Sticky: a pop found the stack empty |

## Verification
The bench builds the unit with DEPTH=4 and AW=8. The shallow stack lets a few pushes reach the full and overflow boundary, and then the empty and underflow boundary, within a short run. The narrow address width keeps each pushed address easy to derive from the loop indices. With these values the bench sweeps all 256 upper instruction bytes against a set of low bytes, including both restore-flag values of the interrupt return. For every word it predicts from the two encodings whether a pop happens and what W receives. Directed sequences then cover shadow capture and restore under each priority setting, strobes in the idle cycle, pushes that collide with a strobe, and both sticky error flags.

// File: rtl/rsu_pkg.sv
package rsu_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RFI  = 2'd1,
    OP_RLW  = 2'd2
  } rsu_op_e;

  localparam logic [14:0] RFI_UPPER = 15'h0008;
  localparam logic [7:0]  RLW_UPPER = 8'h0C;
endpackage

// File: rtl/rsu_decode.sv
module rsu_decode
  import rsu_pkg::*;
(
  input  logic [15:0] instr,
  output rsu_op_e     op,
  output logic        restore,
  output logic [7:0]  literal
);
  always_comb begin
    op = OP_NONE;
    if (instr[15:1] == RFI_UPPER)      op = OP_RFI;
    else if (instr[15:8] == RLW_UPPER) op = OP_RLW;
  end

  assign restore = instr[0];
  assign literal = instr[7:0];
endmodule

// File: rtl/rsu_stack.sv
module rsu_stack #(
  parameter int AW    = 21,
  parameter int DEPTH = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] tos,
  output logic          overflow,
  output logic          underflow
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr, ptr_n;
  logic          ovf_n, unf_n;
  logic          full, empty, wr_en;

  assign full  = (ptr == FULL_LVL);
  assign empty = (ptr == '0);
  assign wr_en = push && !full;
  assign tos   = empty ? '0 : mem[ptr - 1'b1];

  always_comb begin
    ptr_n = ptr;
    ovf_n = overflow;
    unf_n = underflow;
    if (push) begin
      if (full) ovf_n = 1'b1;
      else      ptr_n = ptr + 1'b1;
    end else if (pop) begin
      if (empty) unf_n = 1'b1;
      else       ptr_n = ptr - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      ptr       <= ptr_n;
      overflow  <= ovf_n;
      underflow <= unf_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[ptr] <= push_data;
  end

  p_level_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= FULL_LVL);
  p_full_push_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (overflow && ptr == FULL_LVL));
  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_underflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  p_empty_pop_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> (underflow && ptr == '0));
endmodule

// File: rtl/rsu_shadow.sv
module rsu_shadow #(
  parameter int SW = 8,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [7:0]    w_in,
  input  logic [SW-1:0] st_in,
  input  logic [BW-1:0] bsr_in,
  output logic [7:0]    sh_w,
  output logic [SW-1:0] sh_st,
  output logic [BW-1:0] sh_bsr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_w   <= '0;
      sh_st  <= '0;
      sh_bsr <= '0;
    end else if (capture) begin
      sh_w   <= w_in;
      sh_st  <= st_in;
      sh_bsr <= bsr_in;
    end
  end

  p_shadow_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (sh_w == $past(w_in) && sh_st == $past(st_in) && sh_bsr == $past(bsr_in)));
  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(sh_w) && $stable(sh_st) && $stable(sh_bsr)));
endmodule

// File: rtl/ret_stack_unit.sv
module ret_stack_unit
  import rsu_pkg::*;
#(
  parameter int AW          = 21,
  parameter int DEPTH       = 31,
  parameter int SW          = 8,
  parameter int BW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   instr,
  input  logic          dec_stb,
  input  logic          call_push,
  input  logic          irq_push,
  input  logic [AW-1:0] ret_addr,
  input  logic [7:0]    w_cur,
  input  logic [SW-1:0] status_cur,
  input  logic [BW-1:0] bsr_cur,
  input  logic          prio_mode,
  input  logic          hi_in_service,
  output logic          pc_load,
  output logic [AW-1:0] pc_val,
  output logic          w_load,
  output logic [7:0]    w_val,
  output logic          status_load,
  output logic [SW-1:0] status_val,
  output logic          bsr_load,
  output logic [BW-1:0] bsr_val,
  output logic          ie_high_set,
  output logic          ie_low_set,
  output logic          stk_overflow,
  output logic          stk_underflow
);
  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[SYNC_STAGES-1];

  rsu_op_e       op;
  logic          restore;
  logic [7:0]    literal;
  logic          push_any, accept, is_rfi, is_rlw;
  logic [AW-1:0] tos;
  logic [7:0]    sh_w;
  logic [SW-1:0] sh_st;
  logic [BW-1:0] sh_bsr;

  rsu_decode u_dec (
    .instr   (instr),
    .op      (op),
    .restore (restore),
    .literal (literal)
  );

  assign push_any = call_push || irq_push;
  assign accept   = dec_stb && !pc_load && !push_any && (op != OP_NONE);
  assign is_rfi   = accept && (op == OP_RFI);
  assign is_rlw   = accept && (op == OP_RLW);

  rsu_stack #(.AW(AW), .DEPTH(DEPTH)) u_stk (
    .clk       (clk),
    .rst_n     (rst_q),
    .push      (push_any),
    .pop       (accept),
    .push_data (ret_addr),
    .tos       (tos),
    .overflow  (stk_overflow),
    .underflow (stk_underflow)
  );

  rsu_shadow #(.SW(SW), .BW(BW)) u_shd (
    .clk     (clk),
    .rst_n   (rst_q),
    .capture (irq_push),
    .w_in    (w_cur),
    .st_in   (status_cur),
    .bsr_in  (bsr_cur),
    .sh_w    (sh_w),
    .sh_st   (sh_st),
    .sh_bsr  (sh_bsr)
  );

  // next-state of the result registers
  logic          pc_load_n, w_load_n, st_load_n, bsr_load_n, ieh_n, iel_n;
  logic [AW-1:0] pc_val_n;
  logic [7:0]    w_val_n;
  logic [SW-1:0] st_val_n;
  logic [BW-1:0] bsr_val_n;

  always_comb begin
    pc_load_n  = accept;
    pc_val_n   = accept ? tos : pc_val;
    w_load_n   = is_rlw || (is_rfi && restore);
    st_load_n  = is_rfi && restore;
    bsr_load_n = is_rfi && restore;
    w_val_n    = w_val;
    st_val_n   = status_val;
    bsr_val_n  = bsr_val;
    if (is_rlw) w_val_n = literal;
    if (is_rfi && restore) begin
      w_val_n   = sh_w;
      st_val_n  = sh_st;
      bsr_val_n = sh_bsr;
    end
    ieh_n = is_rfi && (!prio_mode || hi_in_service);
    iel_n = is_rfi && prio_mode && !hi_in_service;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      pc_load     <= 1'b0;
      pc_val      <= '0;
      w_load      <= 1'b0;
      w_val       <= '0;
      status_load <= 1'b0;
      status_val  <= '0;
      bsr_load    <= 1'b0;
      bsr_val     <= '0;
      ie_high_set <= 1'b0;
      ie_low_set  <= 1'b0;
    end else begin
      pc_load     <= pc_load_n;
      pc_val      <= pc_val_n;
      w_load      <= w_load_n;
      w_val       <= w_val_n;
      status_load <= st_load_n;
      status_val  <= st_val_n;
      bsr_load    <= bsr_load_n;
      bsr_val     <= bsr_val_n;
      ie_high_set <= ieh_n;
      ie_low_set  <= iel_n;
    end
  end

  p_idle_slot_r8: assert property (@(posedge clk) disable iff (!rst_q)
    pc_load |=> !pc_load);
  p_push_wins_r9: assert property (@(posedge clk) disable iff (!rst_q)
    push_any |=> !pc_load);
  p_unknown_quiet_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (op == OP_NONE) |=> !pc_load);
  p_enable_onehot_r6: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({ie_high_set, ie_low_set}));
  p_enable_with_pop_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (ie_high_set || ie_low_set) |-> pc_load);
  p_restore_group_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (bsr_load || status_load) |-> (bsr_load && status_load && w_load && pc_load));
  p_literal_value_r2: assert property (@(posedge clk) disable iff (!rst_q)
    is_rlw |=> (w_load && w_val == $past(instr[7:0])));
endmodule

// File: tb/ret_stack_unit_tb_top.sv
module ret_stack_unit_tb_top;
  localparam int AW = 8;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   instr;
  logic          dec_stb, call_push, irq_push, prio_mode, hi_in_service;
  logic [AW-1:0] ret_addr;
  logic [7:0]    w_cur;
  logic [7:0]    status_cur;
  logic [3:0]    bsr_cur;
  logic          pc_load, w_load, status_load, bsr_load, ie_high_set, ie_low_set;
  logic          stk_overflow, stk_underflow;
  logic [AW-1:0] pc_val;
  logic [7:0]    w_val, status_val;
  logic [3:0]    bsr_val;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ret_stack_unit #(.AW(AW), .DEPTH(DEPTH), .SW(8), .BW(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .instr(instr), .dec_stb(dec_stb),
    .call_push(call_push), .irq_push(irq_push), .ret_addr(ret_addr),
    .w_cur(w_cur), .status_cur(status_cur), .bsr_cur(bsr_cur),
    .prio_mode(prio_mode), .hi_in_service(hi_in_service),
    .pc_load(pc_load), .pc_val(pc_val), .w_load(w_load), .w_val(w_val),
    .status_load(status_load), .status_val(status_val),
    .bsr_load(bsr_load), .bsr_val(bsr_val),
    .ie_high_set(ie_high_set), .ie_low_set(ie_low_set),
    .stk_overflow(stk_overflow), .stk_underflow(stk_underflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one cycle of inputs; on return the outputs reflect that edge
  task automatic step(input logic stb, input logic [15:0] ins, input logic cp,
                      input logic ip, input logic [AW-1:0] a);
    dec_stb = stb; instr = ins; call_push = cp; irq_push = ip; ret_addr = a;
    @(negedge clk);
    dec_stb = 1'b0; call_push = 1'b0; irq_push = 1'b0;
  endtask

  task automatic push_call(input logic [AW-1:0] a);
    step(1'b0, 16'h0, 1'b1, 1'b0, a);
  endtask

  task automatic idle();
    step(1'b0, 16'h0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] lows [6] = '{8'h00, 8'h01, 8'h10, 8'h11, 8'h5A, 8'hFF};
    rst_n = 1'b0; instr = '0; dec_stb = 0; call_push = 0; irq_push = 0;
    ret_addr = '0; w_cur = '0; status_cur = '0; bsr_cur = '0;
    prio_mode = 0; hi_in_service = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    chk("R12 pc_load", pc_load, 0);
    chk("R12 pc_val", pc_val, 0);
    chk("R12 w_load", w_load, 0);
    chk("R12 ie bits", {ie_high_set, ie_low_set}, 0);
    chk("R12 flags", {stk_overflow, stk_underflow}, 0);

    // R1 R2 R3 R7 sweep over upper byte and chosen low bytes
    for (int h = 0; h < 256; h++) begin
      for (int j = 0; j < 6; j++) begin
        logic [15:0] ins;
        logic [7:0]  a;
        logic        rfi, rlw;
        ins = {h[7:0], lows[j]};
        a   = h[7:0] ^ lows[j] ^ 8'hA5;
        rfi = (ins[15:1] == 15'h0008);
        rlw = (ins[15:8] == 8'h0C);
        push_call(a);
        step(1'b1, ins, 1'b0, 1'b0, '0);
        chk("R1/R2/R7 pc_load", pc_load, rfi || rlw);
        if (rfi || rlw) chk("R3 pc_val", pc_val, a);
        chk("R2/R4 w_load", w_load, rlw || (rfi && ins[0]));
        if (rlw) chk("R2 w_val", w_val, ins[7:0]);
        chk("R2/R4 status_load", status_load, rfi && ins[0]);
        chk("R6 ie_high_set", ie_high_set, rfi);
        chk("R6 ie_low_set", ie_low_set, 0);
        idle();
        if (!(rfi || rlw)) begin
          step(1'b1, 16'h0C00, 1'b0, 1'b0, '0);
          chk("R7 stack intact", pc_val, a);
          idle();
        end
      end
    end
    chk("R11 no underflow after sweep", stk_underflow, 0);

    // R5 R4 R6 shadow capture and restore
    w_cur = 8'h5A; status_cur = 8'h3C; bsr_cur = 4'h9;
    step(1'b0, 16'h0, 1'b0, 1'b1, 8'h33);
    w_cur = 8'h11; status_cur = 8'h22; bsr_cur = 4'h3;
    push_call(8'h44);
    w_cur = 8'hEE; status_cur = 8'hDD; bsr_cur = 4'h1;
    prio_mode = 1; hi_in_service = 1;
    step(1'b1, 16'h0011, 1'b0, 1'b0, '0);
    chk("R3 pc after call", pc_val, 8'h44);
    chk("R5 R4 w from shadow", w_val, 8'h5A);
    chk("R5 R4 status from shadow", status_val, 8'h3C);
    chk("R5 R4 bsr from shadow", bsr_val, 4'h9);
    chk("R4 loads", {w_load, status_load, bsr_load}, 3'b111);
    chk("R6 high in service", {ie_high_set, ie_low_set}, 2'b10);
    idle();
    hi_in_service = 0;
    step(1'b1, 16'h0010, 1'b0, 1'b0, '0);
    chk("R3 pc after irq", pc_val, 8'h33);
    chk("R4 no restore", {w_load, status_load, bsr_load}, 3'b000);
    chk("R6 low priority", {ie_high_set, ie_low_set}, 2'b01);
    idle();
    prio_mode = 0;

    // R8 strobe during idle second cycle
    push_call(8'h21);
    push_call(8'h22);
    step(1'b1, 16'h0C07, 1'b0, 1'b0, '0);
    chk("R8 first pop", pc_val, 8'h22);
    chk("R2 literal 07", w_val, 8'h07);
    step(1'b1, 16'h0C08, 1'b0, 1'b0, '0);
    chk("R8 idle strobe ignored", pc_load, 0);
    step(1'b1, 16'h0C09, 1'b0, 1'b0, '0);
    chk("R8 next pop", pc_val, 8'h21);
    chk("R8 next literal", w_val, 8'h09);
    idle();

    // R9 push collides with strobe
    step(1'b1, 16'h0C01, 1'b1, 1'b0, 8'h50);
    chk("R9 strobe dropped", pc_load, 0);
    step(1'b1, 16'h0C02, 1'b0, 1'b0, '0);
    chk("R9 push kept", pc_val, 8'h50);
    chk("R9 literal of retry", w_val, 8'h02);
    idle();

    // R10 overflow
    for (int k = 1; k <= DEPTH; k++) push_call(8'(k));
    chk("R10 full, no overflow", stk_overflow, 0);
    push_call(8'h77);
    chk("R10 overflow set", stk_overflow, 1);
    for (int k = DEPTH; k >= 1; k--) begin
      step(1'b1, 16'h0C00, 1'b0, 1'b0, '0);
      chk("R10 dropped push, pop order", pc_val, k);
      idle();
    end
    chk("R10 overflow sticky", stk_overflow, 1);

    // R11 underflow
    step(1'b1, 16'h0C00, 1'b0, 1'b0, '0);
    chk("R11 empty pop pc_load", pc_load, 1);
    chk("R11 empty pop value", pc_val, 0);
    chk("R11 underflow set", stk_underflow, 1);
    idle();
    idle();
    chk("R11 underflow sticky", stk_underflow, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule